// File: doc/BRIEF.md
# Shift-Register Programmable Clock Divider

This block divides its input clock using maximal-length shift registers instead of binary counters. Each divider stage holds a reload register written by software. The shift register steps through a fixed pseudo-random sequence until it reaches an all-ones terminal state. At that point it reloads, pulses a tick output and toggles its divided clock. To get a divide ratio d, software loads the sequence element that lies d-1 steps before the terminal state. Each tick therefore comes d cycles after the previous one, and the divided clock has a period of 2d cycles.

There are two such stages. A 6-bit reference divider and an 8-bit feedback divider run side by side from the same clock. A two-stage post-divider counts the feedback divider's ticks and toggles its own output once every pd1 × pd2 ticks. Its settings come from a packed field register. All new settings are staged. A divider picks up a new value only at its next reload, and the post-divider only when its output toggles, so no period is cut short or stretched in the middle.

Top module: `lfsr_clkdiv`

## Requirements
- R1: While rst_n is low, both shift registers hold the all-ones terminal state, so both tick outputs are high and all three clock outputs are low. Reset also sets both reload registers to all ones (divisor 1) and both post-divider factors to 1.
- R2: Reference divider step: the next state is {s[4:0], ~(s[5]^s[4])}, except that 0x00 steps to the terminal 0x3F. The resulting reload/divisor pairs are 0x3F→1, 0x00→2, 0x20→3, 0x10→4, 0x01→64.
- R3: Feedback divider step: the next state is the state shifted left by one, with a new bit 0 equal to the XNOR of bits 7, 3, 2 and 1. The exception is 0x00, which steps to the terminal 0xFF. The resulting pairs are 0xFF→1, 0x00→2, 0x80→3, 0xC0→4, 0x01→256.
- R4: A ref_wr pulse stores wdata[5:0] as the reference reload value. From then on, ref_tick is high for one cycle every d cycles, and ref_div_clk changes at the edge that ends each tick cycle.
- R5: A fb_wr pulse stores wdata[7:0] as the feedback reload value. From then on, fb_tick pulses every d cycles and fb_div_clk toggles at the end of each tick cycle.
- R6: A reload value written part-way through a period takes effect only at the divider's next reload. The period in progress completes with the old divisor.
- R7: A post_wr pulse carries (8-pd1) in wdata[5:3] and (8-pd2) in wdata[2:0], with pd1 and pd2 each from 1 to 8. Bits 7:6 are ignored. Once the setting is active, post_clk toggles once every pd1*pd2 fb_tick pulses, at the end of the tick cycle that completes the count.
- R8: A post_wr whose decoded pd2 is greater than its decoded pd1 is ignored, and the previous setting stays in force.
- R9: An accepted post-divider setting becomes active only at the edge where post_clk toggles. The half-period in progress completes with the old factors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_wr | input | 1 | Write strobe for the reference reload value |
| fb_wr | input | 1 | Write strobe for the feedback reload value |
| post_wr | input | 1 | Write strobe for the packed post-divider fields |
| wdata | input | 8 | Write data shared by the three strobes |
| ref_tick | output | 1 | High in the reference divider's terminal cycle |
| ref_div_clk | output | 1 | Reference divided clock, toggles on every reload |
| fb_tick | output | 1 | High in the feedback divider's terminal cycle |
| fb_div_clk | output | 1 | Feedback divided clock, toggles on every reload |
| post_clk | output | 1 | Post-divided clock driven from the feedback ticks |

## Verification
Some rules are checked by assertions on every cycle: the zero-to-terminal step, the terminal state loading the reload value latched before the edge, the active post factors always keeping pd2 ≤ pd1, factors changing only together with a post_clk toggle, and post_clk moving only after a feedback tick. Other behaviour only the bench scenarios can show, because it depends on how stimulus is timed against the output: the exact tap sequence, checked against the listed reload/divisor pairs, the periods measured at each divisor and post setting, a write landing mid-period, and a rejected post setting.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // width of one packed post-divider field; factors run 1 .. 2**PD_FW
  localparam int PD_FW = 3;

  typedef logic [PD_FW:0] pdiv_t;

  // field holds (2**PD_FW - factor); a zero field means the largest factor
  function automatic pdiv_t fld2div(input logic [PD_FW-1:0] f);
    return pdiv_t'(2 ** PD_FW) - pdiv_t'(f);
  endfunction
endpackage

// File: rtl/lfsr_div.sv
module lfsr_div #(
  parameter int            W    = 6,
  parameter logic [W-1:0]  TAPS = 6'h30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         tick_o,
  output logic         clk_o,
  output logic [W-1:0] state_o,
  output logic [W-1:0] reload_o
);
  localparam logic [W-1:0] TERM = {W{1'b1}};

  // XNOR-feedback step; the all-zero state leads into the terminal state
  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    if (s == '0) return TERM;
    return {s[W-2:0], ~^(s & TAPS)};
  endfunction

  logic [W-1:0] state_q;
  logic [W-1:0] reload_q;
  logic         div_q;
  logic         at_term;

  assign at_term = (state_q == TERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TERM;
      reload_q <= TERM;
      div_q    <= 1'b0;
    end else begin
      if (at_term) begin
        state_q <= reload_q;
        div_q   <= ~div_q;
      end else begin
        state_q <= lfsr_next(state_q);
      end
      if (wr_i) reload_q <= wdata_i;
    end
  end

  assign tick_o   = at_term;
  assign clk_o    = div_q;
  assign state_o  = state_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/post_div.sv
module post_div
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               wr_i,
  input  logic [2*PD_FW-1:0] cfg_i,
  output logic               clk_o,
  output pdiv_t              pd1_o,
  output pdiv_t              pd2_o
);
  pdiv_t            pend1_q, pend2_q, act1_q, act2_q;
  logic [PD_FW-1:0] c1_q, c2_q;
  logic             out_q;
  pdiv_t            new1, new2;
  logic             accept, s1_wrap, s2_wrap;

  assign new1    = fld2div(cfg_i[2*PD_FW-1:PD_FW]);
  assign new2    = fld2div(cfg_i[PD_FW-1:0]);
  assign accept  = wr_i && (new2 <= new1);
  assign s1_wrap = tick_i && ({1'b0, c1_q} == act1_q - pdiv_t'(1));
  assign s2_wrap = s1_wrap && ({1'b0, c2_q} == act2_q - pdiv_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend1_q <= pdiv_t'(1);
      pend2_q <= pdiv_t'(1);
      act1_q  <= pdiv_t'(1);
      act2_q  <= pdiv_t'(1);
      c1_q    <= '0;
      c2_q    <= '0;
      out_q   <= 1'b0;
    end else begin
      if (tick_i) c1_q <= s1_wrap ? '0 : c1_q + 1'b1;
      if (s1_wrap) c2_q <= s2_wrap ? '0 : c2_q + 1'b1;
      if (s2_wrap) begin
        out_q  <= ~out_q;
        act1_q <= pend1_q;
        act2_q <= pend2_q;
      end
      if (accept) begin
        pend1_q <= new1;
        pend2_q <= new2;
      end
    end
  end

  assign clk_o = out_q;
  assign pd1_o = act1_q;
  assign pd2_o = act2_q;
endmodule

// File: rtl/lfsr_clkdiv.sv
module lfsr_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int              M_W    = 6,
  parameter int              N_W    = 8,
  parameter logic [M_W-1:0]  M_TAPS = 6'h30,
  parameter logic [N_W-1:0]  N_TAPS = 8'h8E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_wr,
  input  logic           fb_wr,
  input  logic           post_wr,
  input  logic [N_W-1:0] wdata,
  output logic           ref_tick,
  output logic           ref_div_clk,
  output logic           fb_tick,
  output logic           fb_div_clk,
  output logic           post_clk
);
  // internal events brought out for the bound checker
  logic [M_W-1:0] ref_state, ref_reload;
  logic [N_W-1:0] fb_state, fb_reload;
  pdiv_t          pd1_act, pd2_act;

  lfsr_div #(.W(M_W), .TAPS(M_TAPS)) u_ref (
    .clk(clk), .rst_n(rst_n), .wr_i(ref_wr), .wdata_i(wdata[M_W-1:0]),
    .tick_o(ref_tick), .clk_o(ref_div_clk),
    .state_o(ref_state), .reload_o(ref_reload)
  );

  lfsr_div #(.W(N_W), .TAPS(N_TAPS)) u_fb (
    .clk(clk), .rst_n(rst_n), .wr_i(fb_wr), .wdata_i(wdata),
    .tick_o(fb_tick), .clk_o(fb_div_clk),
    .state_o(fb_state), .reload_o(fb_reload)
  );

  post_div u_post (
    .clk(clk), .rst_n(rst_n), .tick_i(fb_tick), .wr_i(post_wr),
    .cfg_i(wdata[2*PD_FW-1:0]), .clk_o(post_clk),
    .pd1_o(pd1_act), .pd2_o(pd2_act)
  );
endmodule

// File: rtl/lfsr_clkdiv_chk.sv
module lfsr_clkdiv_chk
  import clkdiv_pkg::*;
#(
  parameter int M_W = 6,
  parameter int N_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fb_tick,
  input logic           post_clk,
  input logic [M_W-1:0] ref_state,
  input logic [M_W-1:0] ref_reload,
  input logic [N_W-1:0] fb_state,
  input logic [N_W-1:0] fb_reload,
  input pdiv_t          pd1_act,
  input pdiv_t          pd2_act
);
  a_r2_zero_to_term: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_state == '0) |=> (ref_state == '1));

  a_r3_zero_to_term: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_state == '0) |=> (fb_state == '1));

  a_r4_term_loads_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_state == '1) |=> (ref_state == $past(ref_reload)));

  a_r5_term_loads_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_state == '1) |=> (fb_state == $past(fb_reload)));

  a_r7_toggle_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (post_clk != $past(post_clk)) |-> $past(fb_tick));

  a_r8_active_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pd1_act != '0) && (pd2_act != '0) && (pd2_act <= pd1_act));

  a_r9_apply_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd1_act != $past(pd1_act)) || (pd2_act != $past(pd2_act)))
      |-> (post_clk != $past(post_clk)));
endmodule

bind lfsr_clkdiv lfsr_clkdiv_chk #(.M_W(M_W), .N_W(N_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_tick(fb_tick), .post_clk(post_clk),
  .ref_state(ref_state), .ref_reload(ref_reload),
  .fb_state(fb_state), .fb_reload(fb_reload),
  .pd1_act(pd1_act), .pd2_act(pd2_act)
);

// File: tb/lfsr_clkdiv_tb.sv
module lfsr_clkdiv_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ref_wr = 1'b0, fb_wr = 1'b0, post_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic ref_tick, ref_div_clk, fb_tick, fb_div_clk, post_clk;

  int n_checks = 0;
  int n_errors = 0;
  bit cmp_on = 1'b0;

  // reload tables built from the stated step rules (index = divisor)
  int mtab [1:64];
  int ntab [1:256];

  // values the bench attaches to each write
  int m_wd = 1, n_wd = 1, p_d1 = 1, p_d2 = 1;

  // behavioural reference state
  int mc, mp, nc, np, pc1, pc2, pa1, pa2, pp1, pp2;
  bit mo, no, po, ntk;

  always #5 clk = ~clk;

  lfsr_clkdiv u_dut (
    .clk(clk), .rst_n(rst_n), .ref_wr(ref_wr), .fb_wr(fb_wr),
    .post_wr(post_wr), .wdata(wdata), .ref_tick(ref_tick),
    .ref_div_clk(ref_div_clk), .fb_tick(fb_tick), .fb_div_clk(fb_div_clk),
    .post_clk(post_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lstep(input int s, input int w, input int taps);
    int all = (1 << w) - 1;
    if (s == 0) return all;
    return ((s << 1) & all) | ((($countones(s & taps) % 2) == 0) ? 1 : 0);
  endfunction

  // cycle model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mp = 1; mo = 0; nc = 0; np = 1; no = 0;
      pc1 = 0; pc2 = 0; pa1 = 1; pa2 = 1; pp1 = 1; pp2 = 1; po = 0;
    end else begin
      ntk = (nc == 0);
      if (mc == 0) begin mc = mp - 1; mo = ~mo; end else mc--;
      if (nc == 0) begin nc = np - 1; no = ~no; end else nc--;
      if (ntk) begin
        if (pc1 == pa1 - 1) begin
          pc1 = 0;
          if (pc2 == pa2 - 1) begin
            pc2 = 0; po = ~po; pa1 = pp1; pa2 = pp2;
          end else pc2++;
        end else pc1++;
      end
      if (ref_wr) mp = m_wd;
      if (fb_wr) np = n_wd;
      if (post_wr && (p_d2 <= p_d1)) begin pp1 = p_d1; pp2 = p_d2; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(ref_tick == (mc == 0), "R4 model ref_tick", ref_tick, mc == 0);
      check(ref_div_clk == mo, "R4 model ref_div_clk", ref_div_clk, mo);
      check(fb_tick == (nc == 0), "R5 model fb_tick", fb_tick, nc == 0);
      check(fb_div_clk == no, "R5 model fb_div_clk", fb_div_clk, no);
      check(post_clk == po, "R7 model post_clk", post_clk, po);
    end
  end

  task automatic wr_ref(input int d);
    @(negedge clk); ref_wr = 1'b1; wdata = 8'(mtab[d]); m_wd = d;
    @(negedge clk); ref_wr = 1'b0;
  endtask

  task automatic wr_fb(input int d);
    @(negedge clk); fb_wr = 1'b1; wdata = 8'(ntab[d]); n_wd = d;
    @(negedge clk); fb_wr = 1'b0;
  endtask

  task automatic wr_post(input int d1, input int d2, input int hi);
    @(negedge clk); post_wr = 1'b1;
    wdata = 8'((hi << 6) | ((8 - d1) << 3) | (8 - d2)); p_d1 = d1; p_d2 = d2;
    @(negedge clk); post_wr = 1'b0;
  endtask

  task automatic tick_gap(input bit use_fb, output int n);
    do @(negedge clk); while (!(use_fb ? fb_tick : ref_tick));
    n = 0;
    do begin @(negedge clk); n++; end while (!(use_fb ? fb_tick : ref_tick));
  endtask

  task automatic post_gap(output int n);
    logic prev;
    prev = post_clk;
    do @(negedge clk); while (post_clk == prev);
    prev = post_clk; n = 0;
    do begin @(negedge clk); n++; end while (post_clk == prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int s, g, cnt;
    logic prev;
    // build tables by walking each sequence forward from 0x01
    s = 1;
    for (int i = 0; i < 63; i++) begin mtab[64 - i] = s; s = lstep(s, 6, 'h30); end
    mtab[1] = 'h3F;
    s = 1;
    for (int i = 0; i < 255; i++) begin ntab[256 - i] = s; s = lstep(s, 8, 'h8E); end
    ntab[1] = 'hFF;
    check(mtab[1] == 'h3F, "R2 table d1", mtab[1], 'h3F);
    check(mtab[2] == 'h00, "R2 table d2", mtab[2], 'h00);
    check(mtab[3] == 'h20, "R2 table d3", mtab[3], 'h20);
    check(mtab[4] == 'h10, "R2 table d4", mtab[4], 'h10);
    check(mtab[64] == 'h01, "R2 table d64", mtab[64], 'h01);
    check(ntab[2] == 'h00, "R3 table d2", ntab[2], 'h00);
    check(ntab[3] == 'h80, "R3 table d3", ntab[3], 'h80);
    check(ntab[4] == 'hC0, "R3 table d4", ntab[4], 'hC0);
    check(ntab[256] == 'h01, "R3 table d256", ntab[256], 'h01);

    // R1: reset state
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ref_tick == 1'b1, "R1 ref_tick in reset", ref_tick, 1);
    check(fb_tick == 1'b1, "R1 fb_tick in reset", fb_tick, 1);
    check(ref_div_clk == 1'b0, "R1 ref_div_clk in reset", ref_div_clk, 0);
    check(fb_div_clk == 1'b0, "R1 fb_div_clk in reset", fb_div_clk, 0);
    check(post_clk == 1'b0, "R1 post_clk in reset", post_clk, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick_gap(1'b0, g); check(g == 1, "R1 default ref divisor", g, 1);
    tick_gap(1'b1, g); check(g == 1, "R1 default fb divisor", g, 1);
    post_gap(g); check(g == 1, "R1 default post factors", g, 1);

    // R4 / R2: reference divisors
    wr_ref(3); tick_gap(1'b0, g); tick_gap(1'b0, g);
    check(g == 3, "R4 ref divisor 3 (0x20)", g, 3);
    wr_ref(2); tick_gap(1'b0, g); tick_gap(1'b0, g);
    check(g == 2, "R2 ref divisor 2 (0x00)", g, 2);
    wr_ref(64); tick_gap(1'b0, g); tick_gap(1'b0, g);
    check(g == 64, "R2 ref divisor 64 (0x01)", g, 64);
    wr_ref(1); tick_gap(1'b0, g); tick_gap(1'b0, g);
    check(g == 1, "R4 ref divisor 1 (0x3F)", g, 1);

    // R5 / R3: feedback divisors
    wr_fb(5); tick_gap(1'b1, g); tick_gap(1'b1, g);
    check(g == 5, "R5 fb divisor 5", g, 5);
    wr_fb(3); tick_gap(1'b1, g); tick_gap(1'b1, g);
    check(g == 3, "R3 fb divisor 3 (0x80)", g, 3);
    wr_fb(256); tick_gap(1'b1, g); tick_gap(1'b1, g);
    check(g == 256, "R3 fb divisor 256 (0x01)", g, 256);

    // R6: write landing mid-period
    wr_ref(20); tick_gap(1'b0, g); tick_gap(1'b0, g);
    check(g == 20, "R6 ref steady divisor 20", g, 20);
    do @(negedge clk); while (!ref_tick);
    cnt = 0;
    do begin
      @(negedge clk); cnt++;
      if (cnt == 3) begin ref_wr = 1'b1; wdata = 8'(mtab[5]); m_wd = 5; end
      if (cnt == 4) ref_wr = 1'b0;
    end while (!ref_tick);
    check(cnt == 20, "R6 period in progress keeps old divisor", cnt, 20);
    tick_gap(1'b0, g); check(g == 5, "R6 new divisor after reload", g, 5);

    // R7: post factors 3 x 2 with fb divisor 2, upper bits set
    wr_fb(2);
    wr_post(3, 2, 3);
    post_gap(g); post_gap(g); post_gap(g);
    check(g == 12, "R7 post 3x2 over fb 2", g, 12);

    // R8: pd2 > pd1 rejected
    wr_post(2, 4, 0);
    post_gap(g); post_gap(g);
    check(g == 12, "R8 illegal setting ignored", g, 12);
    post_gap(g);
    check(g == 12, "R8 illegal setting still ignored", g, 12);

    // R9: accepted setting waits for the toggle
    prev = post_clk;
    do @(negedge clk); while (post_clk == prev);
    prev = post_clk; cnt = 0;
    do begin
      @(negedge clk); cnt++;
      if (cnt == 3) begin post_wr = 1'b1; wdata = 8'(((8 - 2) << 3) | (8 - 1)); p_d1 = 2; p_d2 = 1; end
      if (cnt == 4) post_wr = 1'b0;
    end while (post_clk == prev);
    check(cnt == 12, "R9 half-period keeps old factors", cnt, 12);
    post_gap(g); check(g == 4, "R9 new factors after toggle", g, 4);

    repeat (50) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule